// File: doc/BRIEF.md
# Software-Triggered Warm Reset Controller

This block sits on the output and input port bus of a small soft processor and gives the program a way to reset its own core on purpose, while leaving a trace of why. A write to one chosen port address produces a single-cycle reset pulse toward the core. A second address holds an 8-bit reason code that software stores before it restarts itself. Two other reset sources are merged into the same registered reset output: a board-level external reset and a fault pulse from the core's call/return stack when it overflows or underflows.

None of the resets produced here clear the controller's own state. Only device configuration clears it, which the design models with initial values. After a restart the program reads a status port. It shows whether the core is on a cold start or a warm restart, and which source caused the last reset. The reason port returns the stored code. Software acknowledges a warm restart by writing a clear bit to the status port.

The boot tracker is a two-state machine. `ST_COLD` means no reset has been seen since configuration, or the last one was acknowledged. `ST_WARM` means a reset has been seen. Transition *hit* (`ST_COLD`→`ST_WARM`) is taken on any active reset source. Transition *ack* (`ST_WARM`→`ST_COLD`) is taken on a status write with bit 0 set and no reset source active. In every other case the state holds.

Top module: `warm_reset_ctrl`

## Requirements
- R1: A cycle with `write_strobe`=1 and `port_id`=RST_PORT (default 0xF0) drives `core_rst` high for exactly the following clock cycle.
- R2: Each cycle in which `stack_fault` is high drives `core_rst` high in the following cycle.
- R3: `core_rst` follows `ext_rst` delayed by one cycle. It stays high while `ext_rst` is held and falls one cycle after release.
- R4: A strobed write to REASON_PORT (default 0xF1) loads `out_port` into the 8-bit reason register. A strobed read of REASON_PORT returns that register on `in_port`.
- R5: No reset source clears the reason register, the warm flag or the last-source code.
- R6: From configuration, `core_rst`=0, the reason register is 0, the warm flag is 0 and the last-source code is 0.
- R7: The status byte read at STATUS_PORT (default 0xF2) is {5'b0, source[1:0], warm}. Any reset source sets warm=1. A strobed status write with bit 0 = 1 clears warm and source to 0. A status write with bit 0 = 0 has no effect.
- R8: When a clear write and a reset source arrive in the same cycle, the reset wins and warm stays 1.
- R9: The source code is 01 for external, 10 for port write and 11 for stack fault. When sources coincide, external beats stack fault and stack fault beats port write.
- R10: A strobed write to RST_PORT with nonzero data loads that data into the reason register at the same edge as the reset request. With zero data the reason register is left unchanged.
- R11: `in_port` is 0 unless `read_strobe`=1 and `port_id` is REASON_PORT or STATUS_PORT.
- R12: Port writes with `write_strobe`=0 cause no reset and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ext_rst | input | 1 | External reset request, active high |
| stack_fault | input | 1 | Stack overflow or underflow fault pulse from the core |
| port_id | input | 8 | Port address from the processor |
| write_strobe | input | 1 | Output write qualifier |
| out_port | input | 8 | Output data from the processor |
| read_strobe | input | 1 | Input read qualifier |
| in_port | output | 8 | Read data toward the processor |
| core_rst | output | 1 | Registered reset to the processor core |

## Verification
The bench targets the places where a careless design would destroy the evidence it is meant to keep. If a reset cleared the reason or the warm flag, the post-restart status reads would come back zero. If a reset came in the same cycle as an acknowledge and lost to it, the status would show cold after a real reset. The bench applies coincident sources to check the priority of the source code, and reset-port writes with zero and nonzero data to check that the reason register is loaded only when the data is nonzero. It also probes unstrobed writes and unmapped reads. A decoder that ignored a strobe would then emit spurious reset pulses, or drive stray data onto `in_port`.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
    typedef enum logic [0:0] {
        ST_COLD = 1'b0,
        ST_WARM = 1'b1
    } boot_state_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'b00,
        SRC_EXT   = 2'b01,
        SRC_PORT  = 2'b10,
        SRC_STACK = 2'b11
    } rst_src_t;
endpackage

// File: rtl/wrc_port_decode.sv
module wrc_port_decode #(
    parameter int          AW          = 8,
    parameter logic [AW-1:0] RST_PORT    = 8'hF0,
    parameter logic [AW-1:0] REASON_PORT = 8'hF1,
    parameter logic [AW-1:0] STATUS_PORT = 8'hF2
) (
    input  logic [AW-1:0] port_id,
    input  logic          write_strobe,
    input  logic          read_strobe,
    output logic          rst_wr,
    output logic          reason_wr,
    output logic          status_wr,
    output logic          reason_rd,
    output logic          status_rd
);
    localparam int NPORT = 3;
    localparam logic [NPORT-1:0][AW-1:0] PORTS = {STATUS_PORT, REASON_PORT, RST_PORT};

    logic [NPORT-1:0] match;

    for (genvar g = 0; g < NPORT; g++) begin : g_match
        assign match[g] = (port_id == PORTS[g]);
    end

    always_comb begin
        rst_wr    = write_strobe && match[0];
        reason_wr = write_strobe && match[1];
        status_wr = write_strobe && match[2];
        reason_rd = read_strobe  && match[1];
        status_rd = read_strobe  && match[2];
    end
endmodule

// File: rtl/wrc_src_arbiter.sv
module wrc_src_arbiter
    import wrc_pkg::*;
(
    input  logic     clk,
    input  logic     ext_rst,
    input  logic     stack_fault,
    input  logic     port_req,
    output rst_src_t src,
    output logic     core_rst
);
    logic core_rst_q = 1'b0;

    always_comb begin
        if (ext_rst)          src = SRC_EXT;
        else if (stack_fault) src = SRC_STACK;
        else if (port_req)    src = SRC_PORT;
        else                  src = SRC_NONE;
    end

    always_ff @(posedge clk) begin
        core_rst_q <= (src != SRC_NONE);
    end

    assign core_rst = core_rst_q;

    p_pulse_has_cause_r1: assert property (@(posedge clk) disable iff (ext_rst)
        core_rst |-> ($past(port_req) || $past(stack_fault) || $past(ext_rst)));
    p_port_pulse_r1: assert property (@(posedge clk) disable iff (ext_rst)
        port_req |=> core_rst);
    p_fault_pulse_r2: assert property (@(posedge clk) disable iff (ext_rst)
        stack_fault |=> core_rst);
    p_quiet_no_pulse_r12: assert property (@(posedge clk) disable iff (ext_rst)
        (!port_req && !stack_fault) |=> !core_rst);
endmodule

// File: rtl/wrc_boot_fsm.sv
module wrc_boot_fsm
    import wrc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          ext_rst,
    input  rst_src_t      src,
    input  logic          status_wr,
    input  logic          reason_wr,
    input  logic          rst_wr,
    input  logic [DW-1:0] din,
    output logic          warm,
    output rst_src_t      last_src,
    output logic [DW-1:0] reason
);
    boot_state_t   state_q = ST_COLD;
    boot_state_t   state_d;
    rst_src_t      src_q   = SRC_NONE;
    logic [DW-1:0] reason_q = '0;
    logic          clear_req;
    logic          any_src;
    logic          reason_load;

    assign any_src     = (src != SRC_NONE);
    assign clear_req   = status_wr && din[0];
    assign reason_load = reason_wr || (rst_wr && (din != '0));

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLD: if (any_src) state_d = ST_WARM;
            ST_WARM: if (clear_req && !any_src) state_d = ST_COLD;
            default: state_d = ST_COLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (any_src)        src_q <= src;
        else if (clear_req) src_q <= SRC_NONE;
        if (reason_load)    reason_q <= din;
    end

    assign warm     = (state_q == ST_WARM);
    assign last_src = src_q;
    assign reason   = reason_q;

    p_warm_sticky_r5: assert property (@(posedge clk) disable iff (ext_rst)
        (warm && !clear_req) |=> warm);
    p_reset_sets_warm_r7: assert property (@(posedge clk)
        any_src |=> warm);
    p_reset_beats_clear_r8: assert property (@(posedge clk)
        (any_src && clear_req) |=> (warm && last_src != SRC_NONE));
    p_reason_holds_r5: assert property (@(posedge clk) disable iff (ext_rst)
        (!reason_wr && !rst_wr) |=> $stable(reason));
endmodule

// File: rtl/warm_reset_ctrl.sv
module warm_reset_ctrl
    import wrc_pkg::*;
#(
    parameter int            AW          = 8,
    parameter int            DW          = 8,
    parameter logic [AW-1:0] RST_PORT    = 8'hF0,
    parameter logic [AW-1:0] REASON_PORT = 8'hF1,
    parameter logic [AW-1:0] STATUS_PORT = 8'hF2
) (
    input  logic          clk,
    input  logic          ext_rst,
    input  logic          stack_fault,
    input  logic [AW-1:0] port_id,
    input  logic          write_strobe,
    input  logic [DW-1:0] out_port,
    input  logic          read_strobe,
    output logic [DW-1:0] in_port,
    output logic          core_rst
);
    localparam int STAT_USED = 3;

    logic          rst_wr, reason_wr, status_wr, reason_rd, status_rd;
    rst_src_t      src, last_src;
    logic          warm;
    logic [DW-1:0] reason;
    logic [DW-1:0] status;

    wrc_port_decode #(
        .AW(AW), .RST_PORT(RST_PORT), .REASON_PORT(REASON_PORT), .STATUS_PORT(STATUS_PORT)
    ) u_decode (
        .port_id(port_id), .write_strobe(write_strobe), .read_strobe(read_strobe),
        .rst_wr(rst_wr), .reason_wr(reason_wr), .status_wr(status_wr),
        .reason_rd(reason_rd), .status_rd(status_rd)
    );

    wrc_src_arbiter u_arb (
        .clk(clk), .ext_rst(ext_rst), .stack_fault(stack_fault),
        .port_req(rst_wr), .src(src), .core_rst(core_rst)
    );

    wrc_boot_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .ext_rst(ext_rst), .src(src), .status_wr(status_wr),
        .reason_wr(reason_wr), .rst_wr(rst_wr), .din(out_port),
        .warm(warm), .last_src(last_src), .reason(reason)
    );

    assign status = {{(DW-STAT_USED){1'b0}}, last_src, warm};

    always_comb begin
        if (reason_rd)      in_port = reason;
        else if (status_rd) in_port = status;
        else                in_port = '0;
    end

    p_idle_bus_r11: assert property (@(posedge clk)
        !read_strobe |-> (in_port == '0));
endmodule

// File: tb/warm_reset_ctrl_tb.sv
module warm_reset_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] P_RST = 8'hF0, P_RSN = 8'hF1, P_STA = 8'hF2;

    logic       clk = 1'b0;
    logic       ext_rst = 1'b0, stack_fault = 1'b0, write_strobe = 1'b0, read_strobe = 1'b0;
    logic [7:0] port_id = 8'h00, out_port = 8'h00;
    logic [7:0] in_port;
    logic       core_rst;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    int m_warm = 0, m_src = 0, m_reason = 0, m_core = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    warm_reset_ctrl u_dut (
        .clk(clk), .ext_rst(ext_rst), .stack_fault(stack_fault), .port_id(port_id),
        .write_strobe(write_strobe), .out_port(out_port), .read_strobe(read_strobe),
        .in_port(in_port), .core_rst(core_rst)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_read(input bit rs, input int pid);
        if (rs && pid == P_RSN) return m_reason;
        if (rs && pid == P_STA) return (m_src << 1) | m_warm;
        return 0;
    endfunction

    // one clock: drive at negedge, compare read data, advance model at posedge, compare reset
    task automatic step(input string tag, input bit e, input bit sf, input int pid,
                        input bit ws, input int od, input bit rs);
        int s;
        ext_rst = e; stack_fault = sf; port_id = pid[7:0];
        write_strobe = ws; out_port = od[7:0]; read_strobe = rs;
        #1;
        check({tag, " in_port"}, in_port, model_read(rs, pid));
        @(posedge clk);
        s = e ? 1 : sf ? 3 : (ws && pid == P_RST) ? 2 : 0;
        m_core = (s != 0);
        if (s != 0) begin m_warm = 1; m_src = s; end
        else if (ws && pid == P_STA && od[0]) begin m_warm = 0; m_src = 0; end
        if (ws && pid == P_RSN) m_reason = od;
        else if (ws && pid == P_RST && od != 0) m_reason = od;
        @(negedge clk);
        check({tag, " core_rst"}, core_rst, m_core);
    endtask

    task automatic idle(input string tag);
        step(tag, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rd(input string tag, input int pid, input int exp);
        step(tag, 0, 0, pid, 0, 0, 1);
        port_id = pid[7:0]; read_strobe = 1'b1; #1;
        check({tag, " direct"}, in_port, exp);
        read_strobe = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        // R6: configuration state
        check("R6 core_rst", core_rst, 0);
        rd("R6 status", P_STA, 8'h00);
        rd("R6 reason", P_RSN, 8'h00);
        // R4: reason write and read back
        step("R4 write", 0, 0, P_RSN, 1, 8'h21, 0);
        rd("R4 read", P_RSN, 8'h21);
        // R1/R10: reset port, zero data keeps reason
        step("R1 trigger", 0, 0, P_RST, 1, 0, 0);
        check("R1 pulse", core_rst, 1);
        idle("R1 single");
        check("R1 drop", core_rst, 0);
        rd("R10 reason kept", P_RSN, 8'h21);
        rd("R9 port source", P_STA, 8'h05);
        // R7: clear bit0=0 ignored, bit0=1 clears
        step("R7 noclr", 0, 0, P_STA, 1, 8'hFE, 0);
        rd("R7 still warm", P_STA, 8'h05);
        step("R7 clear", 0, 0, P_STA, 1, 8'h01, 0);
        rd("R7 cleared", P_STA, 8'h00);
        // R2: stack fault
        step("R2 fault", 0, 1, 0, 0, 0, 0);
        check("R2 pulse", core_rst, 1);
        rd("R9 stack source", P_STA, 8'h07);
        rd("R5 reason survives", P_RSN, 8'h21);
        // R3: external reset held three cycles
        for (int i = 0; i < 3; i++) step("R3 held", 1, 0, 0, 0, 0, 0);
        check("R3 high", core_rst, 1);
        idle("R3 release");
        check("R3 trailing", core_rst, 0);
        rd("R9 ext source", P_STA, 8'h03);
        rd("R5 reason after ext", P_RSN, 8'h21);
        // R9: priority
        step("R9 stack over port", 0, 1, P_RST, 1, 0, 0);
        rd("R9 prio stack", P_STA, 8'h07);
        step("R9 ext over stack", 1, 1, 0, 0, 0, 0);
        idle("R9 gap");
        rd("R9 prio ext", P_STA, 8'h03);
        // R8: clear coincident with a fault
        step("R8 clear+fault", 0, 1, P_STA, 1, 8'h01, 0);
        rd("R8 stays warm", P_STA, 8'h07);
        // R10: reset port with nonzero data
        step("R10 load", 0, 0, P_RST, 1, 8'h5A, 0);
        rd("R10 reason", P_RSN, 8'h5A);
        // R12: unstrobed writes
        step("R12 no strobe rst", 0, 0, P_RST, 0, 8'h33, 0);
        check("R12 no pulse", core_rst, 0);
        step("R12 no strobe rsn", 0, 0, P_RSN, 0, 8'h44, 0);
        rd("R12 reason kept", P_RSN, 8'h5A);
        // R11: unmapped and unstrobed reads
        step("R11 unmapped", 0, 0, 8'h10, 0, 0, 1);
        step("R11 no strobe", 0, 0, P_RSN, 0, 0, 0);
        step("R11 rst port read", 0, 0, P_RST, 0, 0, 1);
        idle("end");
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule